// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move a run of bytes between a single data port and a local buffer memory without presenting an address on every access. The host first loads a 16-bit start address and a 16-bit byte count, one byte per register write, and optionally sets the receive-ring start and stop pages. It then issues a read or write command. From then on, each strobe on the data port moves either one byte or one little-endian 16-bit word, depending on a width bit in a configuration register. The address steps forward and the count steps down after each access.

When the stepped address lands exactly on the ring stop page, it jumps back to the ring start page. Only two address ranges are decoded. The first is a 32-byte identity area built from a station-address input. The second is a buffer window in an external memory. Reads outside both ranges return all ones, and writes outside them are dropped. When the count runs out, or when a read or write command is issued with the count already at zero, a sticky completion flag is raised. The host clears it through an acknowledge register.

Registers are selected by `reg_sel`: 0 address low byte, 1 address high byte, 2 count low byte, 3 count high byte, 4 configuration (bit 0 = word mode), 5 ring start page, 6 ring stop page, 7 command (bit 0 = read, bit 1 = write), 8 acknowledge (any write clears the flag).

Top module: `rdma_port_engine`

## Requirements
- R1: While reset is held, the address, the remaining count and the completion flag all read zero.
- R2: Writing either byte of the address or of the count replaces only that byte, and the other byte keeps its value.
- R3: In byte mode, a data-port write stores `port_wdata[7:0]` at the current address. A read returns that byte in `port_rdata[7:0]` with the upper byte zero. The address then rises by 1 and the count falls by 1.
- R4: In word mode, the access uses the current address with bit 0 cleared. The byte at the even address maps to data bits 7:0 and the next byte maps to bits 15:8. The address then rises by 2 and the count falls by 2.
- R5: When the stepped address equals the ring stop page times 256, the address is loaded with the ring start page times 256 instead.
- R6: An access made with the count at or below the step size sets the count to zero and raises the completion flag. Otherwise the flag is unchanged.
- R7: A data-port write while the count is zero does not write memory, does not move the address and does not raise the flag.
- R8: A command write with bit 0 or bit 1 set while the count is zero raises the flag on the next cycle. The same command with a nonzero count, or a command with neither bit set, leaves the flag unchanged.
- R9: Addresses from 32 up to the window base, and from the window end upward, are not decoded. Reads there return 0x00FF in byte mode and 0xFFFF in word mode, writes there never assert `mem_we`, and the address and count still step.
- R10: Byte k of the identity area (k = address / 2, so each value appears at two addresses) is station byte k for k < 6, where station byte 0 is `station_addr[7:0]`. It is 0x57 for k = 14 and 15, and zero otherwise. Writes to this area are dropped.
- R11: A write to the acknowledge register clears the completion flag when no access completes in that cycle.
- R12: A data-port read while the count is zero still steps the address, keeps the count at zero and raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| port_wr | input | 1 | Data-port write strobe |
| port_rd | input | 1 | Data-port read strobe |
| port_wdata | input | 16 | Data-port write data |
| port_rdata | output | 16 | Data-port read data for the current address |
| station_addr | input | 48 | Station address shown in the identity area |
| mem_we | output | 1 | Buffer memory write enable |
| mem_be | output | 2 | Buffer memory byte-lane enables |
| mem_addr | output | WIN_AW | Word index within the buffer window |
| mem_wdata | output | 16 | Buffer memory write data |
| mem_rdata | input | 16 | Buffer memory read data, combinational |
| cur_addr | output | 16 | Current transfer address |
| remaining | output | 16 | Remaining byte count |
| xfer_done | output | 1 | Sticky completion flag |

## Verification
The checker assumes the host asserts at most one of `reg_we`, `port_rd` and `port_wr` in any cycle. It also assumes the external memory answers `mem_rdata` within the same cycle as `mem_addr`. The bench keeps to both: each task raises a single strobe for one cycle with an idle cycle between tasks, and its memory model reads combinationally.

The sweeps cover:
- a full ring fill in byte mode and a full read-back in word mode, both ending on a wrap;
- odd word addresses;
- out-of-window addresses that would alias into the small memory if decoding were wrong;
- every byte of the identity area.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   typedef enum logic [3:0] {
      SEL_ADDR_LO    = 4'd0,
      SEL_ADDR_HI    = 4'd1,
      SEL_CNT_LO     = 4'd2,
      SEL_CNT_HI     = 4'd3,
      SEL_CFG        = 4'd4,
      SEL_RING_START = 4'd5,
      SEL_RING_STOP  = 4'd6,
      SEL_CMD        = 4'd7,
      SEL_ACK        = 4'd8
   } rdma_sel_e;

   localparam int CFG_WORD_BIT = 0;
   localparam int CMD_RD_BIT   = 0;
   localparam int CMD_WR_BIT   = 1;

endpackage

// File: rtl/rdma_step.sv
module rdma_step #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   localparam int PAGE_W = ADDR_W - 8
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [CNT_W-1:0]  remaining,
   input  logic              word_mode,
   input  logic [PAGE_W-1:0] start_page,
   input  logic [PAGE_W-1:0] stop_page,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] next_addr,
   output logic [CNT_W-1:0]  next_cnt,
   output logic              completes
);

   logic [ADDR_W-1:0] stride_a;
   logic [CNT_W-1:0]  stride_c;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] stop_a;
   logic [ADDR_W-1:0] start_a;

   assign stride_a  = word_mode ? ADDR_W'(2) : ADDR_W'(1);
   assign stride_c  = word_mode ? CNT_W'(2)  : CNT_W'(1);
   assign acc_addr  = word_mode ? {cur_addr[ADDR_W-1:1], 1'b0} : cur_addr;
   assign sum       = cur_addr + stride_a;
   assign stop_a    = {stop_page, 8'h00};
   assign start_a   = {start_page, 8'h00};
   assign next_addr = (sum == stop_a) ? start_a : sum;
   assign completes = (remaining <= stride_c);
   assign next_cnt  = completes ? '0 : remaining - stride_c;

endmodule

// File: rtl/rdma_regs.sv
module rdma_regs
   import rdma_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int RST_START = 'h40,
   parameter int RST_STOP  = 'hC0,
   localparam int PAGE_W   = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  rdma_sel_e         reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              step_en,
   input  logic              completes,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic [CNT_W-1:0]  next_cnt,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  remaining,
   output logic              word_mode,
   output logic [PAGE_W-1:0] start_page,
   output logic [PAGE_W-1:0] stop_page,
   output logic              xfer_done
);

   logic cmd_zero;
   logic ack;
   logic step_fin;

   assign cmd_zero = reg_we && (reg_sel == SEL_CMD) && (remaining == '0) &&
                     (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
   assign ack      = reg_we && (reg_sel == SEL_ACK);
   assign step_fin = step_en && completes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr   <= '0;
         remaining  <= '0;
         word_mode  <= 1'b0;
         start_page <= PAGE_W'(RST_START);
         stop_page  <= PAGE_W'(RST_STOP);
         xfer_done  <= 1'b0;
      end else begin
         if (step_en) begin
            cur_addr  <= next_addr;
            remaining <= next_cnt;
         end else if (reg_we) begin
            case (reg_sel)
               SEL_ADDR_LO:    cur_addr[7:0]         <= reg_wdata;
               SEL_ADDR_HI:    cur_addr[ADDR_W-1:8]  <= reg_wdata[ADDR_W-9:0];
               SEL_CNT_LO:     remaining[7:0]        <= reg_wdata;
               SEL_CNT_HI:     remaining[CNT_W-1:8]  <= reg_wdata[CNT_W-9:0];
               SEL_CFG:        word_mode             <= reg_wdata[CFG_WORD_BIT];
               SEL_RING_START: start_page            <= reg_wdata[PAGE_W-1:0];
               SEL_RING_STOP:  stop_page             <= reg_wdata[PAGE_W-1:0];
               default: ;
            endcase
         end
         if (step_fin || cmd_zero) xfer_done <= 1'b1;
         else if (ack)             xfer_done <= 1'b0;
      end
   end

endmodule

// File: rtl/rdma_window.sv
module rdma_window #(
   parameter int ADDR_W        = 16,
   parameter int WIN_BASE      = 16384,
   parameter int WIN_BYTES     = 32768,
   parameter int ID_BYTES      = 32,
   parameter int MAC_BYTES     = 6,
   parameter int ID_FILL_FIRST = 14,
   parameter logic [7:0] ID_FILL = 8'h57,
   localparam int WIN_AW  = $clog2(WIN_BYTES) - 1,
   localparam int ID_HALF = ID_BYTES / 2,
   localparam int ID_AW   = $clog2(ID_BYTES)
) (
   input  logic [ADDR_W-1:0]      acc_addr,
   input  logic                   word_mode,
   input  logic                   wr_ok,
   input  logic [15:0]            port_wdata,
   input  logic [15:0]            mem_rdata,
   input  logic [MAC_BYTES*8-1:0] station_addr,
   output logic                   mem_we,
   output logic [1:0]             mem_be,
   output logic [WIN_AW-1:0]      mem_addr,
   output logic [15:0]            mem_wdata,
   output logic [15:0]            port_rdata
);

   logic [7:0] id_rom [ID_HALF];
   logic [7:0] id_byte;
   logic [7:0] lane_byte;
   logic       in_id;
   logic       in_win;
   logic [31:0] a32;

   for (genvar j = 0; j < ID_HALF; j++) begin : g_id
      if (j < MAC_BYTES) begin : g_mac
         assign id_rom[j] = station_addr[8*j +: 8];
      end else if (j >= ID_FILL_FIRST) begin : g_fill
         assign id_rom[j] = ID_FILL;
      end else begin : g_zero
         assign id_rom[j] = 8'h00;
      end
   end

   assign a32       = 32'(acc_addr);
   assign in_id     = a32 < 32'(ID_BYTES);
   assign in_win    = (a32 >= 32'(WIN_BASE)) && (a32 < 32'(WIN_BASE + WIN_BYTES));
   assign id_byte   = id_rom[acc_addr[ID_AW-1:1]];
   assign lane_byte = acc_addr[0] ? mem_rdata[15:8] : mem_rdata[7:0];

   assign mem_addr  = WIN_AW'((acc_addr - ADDR_W'(WIN_BASE)) >> 1);
   assign mem_we    = wr_ok && in_win;
   assign mem_be    = word_mode ? 2'b11 : (acc_addr[0] ? 2'b10 : 2'b01);
   assign mem_wdata = word_mode ? port_wdata : {port_wdata[7:0], port_wdata[7:0]};

   always_comb begin
      if (word_mode) begin
         if (in_win)     port_rdata = mem_rdata;
         else if (in_id) port_rdata = {id_byte, id_byte};
         else            port_rdata = 16'hFFFF;
      end else begin
         if (in_win)     port_rdata = {8'h00, lane_byte};
         else if (in_id) port_rdata = {8'h00, id_byte};
         else            port_rdata = 16'h00FF;
      end
   end

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
   import rdma_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int CNT_W         = 16,
   parameter int WIN_BASE      = 16384,
   parameter int WIN_BYTES     = 32768,
   parameter int ID_BYTES      = 32,
   parameter int MAC_BYTES     = 6,
   parameter int ID_FILL_FIRST = 14,
   parameter logic [7:0] ID_FILL = 8'h57,
   localparam int WIN_AW = $clog2(WIN_BYTES) - 1,
   localparam int PAGE_W = ADDR_W - 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [3:0]             reg_sel,
   input  logic [7:0]             reg_wdata,
   input  logic                   port_wr,
   input  logic                   port_rd,
   input  logic [15:0]            port_wdata,
   output logic [15:0]            port_rdata,
   input  logic [MAC_BYTES*8-1:0] station_addr,
   output logic                   mem_we,
   output logic [1:0]             mem_be,
   output logic [WIN_AW-1:0]      mem_addr,
   output logic [15:0]            mem_wdata,
   input  logic [15:0]            mem_rdata,
   output logic [ADDR_W-1:0]      cur_addr,
   output logic [CNT_W-1:0]       remaining,
   output logic                   xfer_done
);

   if (ADDR_W <= 8 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 9..16");
   end
   if (CNT_W <= 8 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 9..16");
   end
   if (WIN_BYTES < 4 || (WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_bad_win
      $error("WIN_BYTES must be a power of two of at least 4");
   end
   if (WIN_BASE % 256 != 0 || WIN_BASE < ID_BYTES ||
       WIN_BASE + WIN_BYTES > (1 << ADDR_W)) begin : g_bad_base
      $error("window must be page aligned, above the identity area and addressable");
   end
   if (ID_BYTES < 2 || (ID_BYTES & (ID_BYTES - 1)) != 0 ||
       2 * MAC_BYTES > ID_BYTES) begin : g_bad_id
      $error("identity area must be a power of two holding the station bytes twice");
   end

   localparam int RST_START = WIN_BASE / 256;
   localparam int RST_STOP  = ((WIN_BASE + WIN_BYTES) / 256) % (1 << PAGE_W);

   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] next_addr;
   logic [CNT_W-1:0]  next_cnt;
   logic              completes;
   logic              word_mode;
   logic [PAGE_W-1:0] start_page;
   logic [PAGE_W-1:0] stop_page;
   logic              wr_ok;
   logic              step_en;

   assign wr_ok   = port_wr && (remaining != '0);
   assign step_en = port_rd || wr_ok;

   rdma_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .RST_START(RST_START), .RST_STOP(RST_STOP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_sel(rdma_sel_e'(reg_sel)), .reg_wdata(reg_wdata),
      .step_en(step_en), .completes(completes),
      .next_addr(next_addr), .next_cnt(next_cnt),
      .cur_addr(cur_addr), .remaining(remaining), .word_mode(word_mode),
      .start_page(start_page), .stop_page(stop_page), .xfer_done(xfer_done)
   );

   rdma_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
      .cur_addr(cur_addr), .remaining(remaining), .word_mode(word_mode),
      .start_page(start_page), .stop_page(stop_page),
      .acc_addr(acc_addr), .next_addr(next_addr), .next_cnt(next_cnt),
      .completes(completes)
   );

   rdma_window #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
      .ID_BYTES(ID_BYTES), .MAC_BYTES(MAC_BYTES),
      .ID_FILL_FIRST(ID_FILL_FIRST), .ID_FILL(ID_FILL)
   ) u_win (
      .acc_addr(acc_addr), .word_mode(word_mode), .wr_ok(wr_ok),
      .port_wdata(port_wdata), .mem_rdata(mem_rdata), .station_addr(station_addr),
      .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .port_rdata(port_rdata)
   );

endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk
   import rdma_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int WIN_BASE  = 16384,
   parameter int WIN_BYTES = 32768,
   parameter int ID_BYTES  = 32,
   localparam int PAGE_W   = ADDR_W - 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              port_rd,
   input logic              port_wr,
   input logic              reg_we,
   input logic [3:0]        reg_sel,
   input logic [1:0]        cmd_bits,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [CNT_W-1:0]  remaining,
   input logic              xfer_done,
   input logic              word_mode,
   input logic [PAGE_W-1:0] start_page,
   input logic [PAGE_W-1:0] stop_page,
   input logic              mem_we,
   input logic [1:0]        mem_be,
   input logic [15:0]       port_rdata
);

   logic              acc;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] start_a;
   logic [ADDR_W-1:0] stop_a;
   logic [ADDR_W-1:0] eff_a;
   logic              outside;
   logic [CNT_W-1:0]  size_c;

   assign acc     = port_rd || (port_wr && remaining != '0);
   assign sum     = cur_addr + (word_mode ? ADDR_W'(2) : ADDR_W'(1));
   assign size_c  = word_mode ? CNT_W'(2) : CNT_W'(1);
   assign start_a = {start_page, 8'h00};
   assign stop_a  = {stop_page, 8'h00};
   assign eff_a   = {cur_addr[ADDR_W-1:1], cur_addr[0] & ~word_mode};
   assign outside = (32'(eff_a) >= 32'(ID_BYTES)) &&
                    ((32'(eff_a) < 32'(WIN_BASE)) || (32'(eff_a) >= 32'(WIN_BASE + WIN_BYTES)));

   // R3 R4
   step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sum != stop_a) |=> cur_addr == $past(sum));

   // R5
   ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sum == stop_a) |=> cur_addr == $past(start_a));

   // R6
   count_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && remaining <= size_c) |=> (remaining == '0 && xfer_done));

   // R4
   word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && word_mode) |-> mem_be == 2'b11);

   // R7
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && remaining == '0) |-> !mem_we);

   // R9
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rd && outside) |-> port_rdata == (word_mode ? 16'hFFFF : 16'h00FF));

   // R8
   zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 4'(SEL_CMD) && (|cmd_bits) && remaining == '0) |=> xfer_done);

   // R11
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 4'(SEL_ACK) && !port_rd && !port_wr) |=> !xfer_done);

endmodule

bind rdma_port_engine rdma_port_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_BASE(WIN_BASE),
   .WIN_BYTES(WIN_BYTES), .ID_BYTES(ID_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .port_rd(port_rd), .port_wr(port_wr),
   .reg_we(reg_we), .reg_sel(reg_sel), .cmd_bits(reg_wdata[1:0]),
   .cur_addr(cur_addr), .remaining(remaining), .xfer_done(xfer_done),
   .word_mode(word_mode), .start_page(start_page), .stop_page(stop_page),
   .mem_we(mem_we), .mem_be(mem_be), .port_rdata(port_rdata)
);

// File: tb/sim_rdma_port_engine.sv
module sim_rdma_port_engine;

   localparam int CLK_PERIOD = 10;
   localparam int WB  = 1024;
   localparam int MAW = $clog2(WB) - 1;
   localparam logic [3:0] S_ALO = 4'd0, S_AHI = 4'd1, S_CLO = 4'd2, S_CHI = 4'd3,
                          S_CFG = 4'd4, S_RST = 4'd5, S_RSP = 4'd6, S_CMD = 4'd7,
                          S_ACK = 4'd8;
   localparam logic [47:0] STATION = 48'h5F4E3D2C1B0A;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we;
   logic [3:0]  reg_sel;
   logic [7:0]  reg_wdata;
   logic        port_wr;
   logic        port_rd;
   logic [15:0] port_wdata;
   logic [15:0] port_rdata;
   logic        mem_we;
   logic [1:0]  mem_be;
   logic [MAW-1:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic [15:0] cur_addr;
   logic [15:0] remaining;
   logic        xfer_done;

   int checks = 0;
   int fails  = 0;

   logic [15:0] bmem [0:(WB/2)-1];

   always #(CLK_PERIOD/2) clk = ~clk;

   rdma_port_engine #(.WIN_BYTES(WB)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .port_wr(port_wr), .port_rd(port_rd),
      .port_wdata(port_wdata), .port_rdata(port_rdata),
      .station_addr(STATION), .mem_we(mem_we), .mem_be(mem_be),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .cur_addr(cur_addr), .remaining(remaining), .xfer_done(xfer_done)
   );

   assign mem_rdata = bmem[mem_addr];

   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_be[0]) bmem[mem_addr][7:0]  <= mem_wdata[7:0];
         if (mem_be[1]) bmem[mem_addr][15:8] <= mem_wdata[15:8];
      end
   end

   function automatic logic [7:0] pat(input logic [15:0] a);
      return 8'(a[7:0] * 8'd3 + {6'd0, a[9:8]} * 8'd17 + 8'h21);
   endfunction

   function automatic logic [7:0] idb(input logic [15:0] a);
      int k;
      k = int'(a) / 2;
      if (k < 6)   return STATION[8*k +: 8];
      if (k >= 14) return 8'h57;
      return 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rw(input logic [3:0] s, input logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic set_addr(input logic [15:0] a);
      rw(S_ALO, a[7:0]);
      rw(S_AHI, a[15:8]);
   endtask

   task automatic set_cnt(input logic [15:0] c);
      rw(S_CLO, c[7:0]);
      rw(S_CHI, c[15:8]);
   endtask

   task automatic pw(input logic [15:0] d, output logic we_seen);
      @(negedge clk);
      port_wr = 1'b1; port_wdata = d;
      #1 we_seen = mem_we;
      @(negedge clk);
      port_wr = 1'b0;
   endtask

   task automatic pr(output logic [15:0] d);
      @(negedge clk);
      port_rd = 1'b1;
      #1 d = port_rdata;
      @(negedge clk);
      port_rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic        we;
      logic [15:0] a;
      rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
      port_wr = 1'b0; port_rd = 1'b0; port_wdata = '0;
      repeat (3) @(negedge clk);
      chk("R1 addr", 32'(cur_addr), 32'h0);
      chk("R1 count", 32'(remaining), 32'h0);
      chk("R1 done", 32'(xfer_done), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 independent halves
      rw(S_ALO, 8'h34); chk("R2 addr lo", 32'(cur_addr), 32'h0034);
      rw(S_AHI, 8'h12); chk("R2 addr hi", 32'(cur_addr), 32'h1234);
      rw(S_ALO, 8'h78); chk("R2 addr lo keeps hi", 32'(cur_addr), 32'h1278);
      rw(S_CLO, 8'hCD); chk("R2 cnt lo", 32'(remaining), 32'h00CD);
      rw(S_CHI, 8'hAB); chk("R2 cnt hi", 32'(remaining), 32'hABCD);
      rw(S_CHI, 8'h01); chk("R2 cnt hi keeps lo", 32'(remaining), 32'h01CD);

      // R3 R5 R6 byte fill of a two-page ring
      rw(S_CFG, 8'h00); rw(S_RST, 8'h40); rw(S_RSP, 8'h42);
      set_addr(16'h4000); set_cnt(16'h0200);
      for (int i = 0; i < 512; i++) begin
         a = 16'h4000 + 16'(i);
         if (i == 511) chk("R6 done before last", 32'(xfer_done), 32'h0);
         pw({8'h00, pat(a)}, we);
         chk("R3 write strobe", 32'(we), 32'h1);
         chk(i == 511 ? "R5 wrap addr" : "R3 addr step", 32'(cur_addr),
             32'(i == 511 ? 16'h4000 : a + 16'h1));
         chk("R3 count step", 32'(remaining), 32'(511 - i));
      end
      chk("R6 done after fill", 32'(xfer_done), 32'h1);
      rw(S_ACK, 8'h00);
      chk("R11 ack clears", 32'(xfer_done), 32'h0);

      // R4 R5 word read-back sweep
      rw(S_CFG, 8'h01); set_addr(16'h4000); set_cnt(16'h0200);
      for (int j = 0; j < 256; j++) begin
         a = 16'h4000 + 16'(2 * j);
         pr(d);
         chk("R4 word data", 32'(d), 32'({pat(a + 16'h1), pat(a)}));
         chk(j == 255 ? "R5 wrap word" : "R4 addr step", 32'(cur_addr),
             32'(j == 255 ? 16'h4000 : a + 16'h2));
         chk("R4 count step", 32'(remaining), 32'(510 - 2 * j));
      end
      chk("R6 done word sweep", 32'(xfer_done), 32'h1);
      rw(S_ACK, 8'h00);

      // R4 R6 odd start in word mode, count 3
      set_addr(16'h4011); set_cnt(16'h0003);
      pr(d);
      chk("R4 odd word data", 32'(d), 32'({pat(16'h4011), pat(16'h4010)}));
      chk("R4 odd addr", 32'(cur_addr), 32'h4013);
      chk("R6 count 1 left", 32'(remaining), 32'h1);
      chk("R6 not yet done", 32'(xfer_done), 32'h0);
      pr(d);
      chk("R4 odd word data 2", 32'(d), 32'({pat(16'h4013), pat(16'h4012)}));
      chk("R6 short count zero", 32'(remaining), 32'h0);
      chk("R6 short count done", 32'(xfer_done), 32'h1);
      rw(S_ACK, 8'h00);

      // R4 little-endian word write, read back by bytes
      set_addr(16'h4100); set_cnt(16'h0002);
      pw(16'hBEEF, we);
      chk("R4 word write count", 32'(remaining), 32'h0);
      rw(S_CFG, 8'h00); set_addr(16'h4100); set_cnt(16'h0002);
      pr(d); chk("R4 low byte at even", 32'(d), 32'h00EF);
      pr(d); chk("R4 high byte at odd", 32'(d), 32'h00BE);
      rw(S_CFG, 8'h01); set_addr(16'h4121); set_cnt(16'h0002);
      pw(16'h1234, we);
      rw(S_CFG, 8'h00); set_addr(16'h4120); set_cnt(16'h0002);
      pr(d); chk("R4 odd write low", 32'(d), 32'h0034);
      pr(d); chk("R4 odd write high", 32'(d), 32'h0012);
      rw(S_ACK, 8'h00);

      // R7 write with zero count
      set_addr(16'h4004);
      pw(16'h00AA, we);
      chk("R7 no mem write", 32'(we), 32'h0);
      chk("R7 addr held", 32'(cur_addr), 32'h4004);
      chk("R7 no done", 32'(xfer_done), 32'h0);
      set_cnt(16'h0001);
      pr(d);
      chk("R7 memory intact", 32'(d), 32'(pat(16'h4004)));
      rw(S_ACK, 8'h00);

      // R9 unmapped addresses
      set_addr(16'h3FFF); set_cnt(16'h0002);
      pw(16'h0055, we);
      chk("R9 write below window", 32'(we), 32'h0);
      chk("R9 addr steps", 32'(cur_addr), 32'h4000);
      set_addr(16'h4400); set_cnt(16'h0002);
      pr(d);
      chk("R9 byte read ones", 32'(d), 32'h00FF);
      chk("R9 addr steps above", 32'(cur_addr), 32'h4401);
      rw(S_CFG, 8'h01); set_addr(16'h8000); set_cnt(16'h0004);
      pr(d);
      chk("R9 word read ones", 32'(d), 32'hFFFF);
      chk("R9 count steps", 32'(remaining), 32'h2);
      set_addr(16'h4400);
      pw(16'hDEAD, we);
      chk("R9 write above window", 32'(we), 32'h0);
      set_addr(16'h4000); set_cnt(16'h0002);
      pr(d);
      chk("R9 no alias", 32'(d), 32'({pat(16'h4001), pat(16'h4000)}));
      rw(S_ACK, 8'h00);

      // R10 identity area
      rw(S_CFG, 8'h00); set_addr(16'h0000); set_cnt(16'h0020);
      for (int k = 0; k < 32; k++) begin
         pr(d);
         chk("R10 id byte", 32'(d), 32'({8'h00, idb(16'(k))}));
      end
      rw(S_CFG, 8'h01); set_addr(16'h0005); set_cnt(16'h0002);
      pr(d);
      chk("R10 id word", 32'(d), 32'({idb(16'h4), idb(16'h4)}));
      rw(S_CFG, 8'h00); set_addr(16'h0002); set_cnt(16'h0001);
      pw(16'h0099, we);
      chk("R10 id write dropped", 32'(we), 32'h0);
      set_addr(16'h0002); set_cnt(16'h0001);
      pr(d);
      chk("R10 id unchanged", 32'(d), 32'({8'h00, idb(16'h2)}));
      rw(S_ACK, 8'h00);

      // R12 read with zero count
      set_addr(16'h4010);
      pr(d);
      chk("R12 addr steps", 32'(cur_addr), 32'h4011);
      chk("R12 count stays", 32'(remaining), 32'h0);
      chk("R12 done", 32'(xfer_done), 32'h1);
      rw(S_ACK, 8'h00);

      // R8 commands
      rw(S_CMD, 8'h01);
      chk("R8 zero-count read cmd", 32'(xfer_done), 32'h1);
      rw(S_ACK, 8'h00);
      set_cnt(16'h0005);
      rw(S_CMD, 8'h02);
      chk("R8 nonzero cmd", 32'(xfer_done), 32'h0);
      rw(S_CLO, 8'h00);
      rw(S_CMD, 8'h00);
      chk("R8 no-op cmd", 32'(xfer_done), 32'h0);
      rw(S_CMD, 8'h02);
      chk("R8 zero-count write cmd", 32'(xfer_done), 32'h1);
      rw(S_ACK, 8'h00);
      chk("R11 ack final", 32'(xfer_done), 32'h0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule